// File: doc/BRIEF.md
# Floating-point register stack manager

This block keeps the bookkeeping for an eight-entry floating-point register file that is addressed as a stack. A 3-bit top pointer names the physical register that is the current ST(0). Any stack-relative operand ST(i) maps to the physical register (top + i) mod 8. One empty/valid tag per register records whether the slot holds a value. An arithmetic unit next to the block reads ST(0) and ST(i) combinationally, computes a result and returns it, together with a round-up flag, on the same cycle it issues the operation. The block writes that result to ST(0) or ST(i), as the operation form selects. For the popping forms it then pops the stack in a second cycle.

A small sequencer controls the pop. In state `S_IDLE` the block accepts one operation or one push per cycle. An accepted operation that needs a pop and has no underflow writes its result on that clock edge. It then moves the sequencer to `S_POP` (transition IDLE_TO_POP). In `S_POP` the register at ST(0) is tagged empty and the pointer advances by one. The sequencer then always returns to `S_IDLE` (transition POP_TO_IDLE). All other cases stay in `S_IDLE` (transition IDLE_HOLD). If an operand register is empty, the block reports stack underflow, forces the C1 status bit to 0 and changes nothing else. A push input lets a test or a loader put values on the stack.

Top module: `fpstk_mgr`

## Requirements
- R1: After reset, the top pointer is 0, all eight tags read empty (`tag_empty_o` = 8'hFF), `busy_o` = 0, `underflow_o` = 0 and `c1_o` = 0.
- R2: A push accepted in `S_IDLE` with `op_valid_i` low decrements the top pointer mod 8. It writes `push_data_i` into the new ST(0) and tags it valid, visible from the next cycle. A push is ignored while `op_valid_i` is high or while `busy_o` is high.
- R3: `st0_data_o` combinationally shows physical register top, and `sti_data_o` shows physical register (top + i) mod 8, wrapping past 7 to 0. Here i is `op_idx_i`, or 1 for form 4. Bit p of `tag_empty_o` is the tag of physical register p.
- R4: `op_form_i` encodings: 0 reads only ST(0) and writes ST(0). 1 reads ST(0) and ST(i) and writes ST(0). 2 reads both and writes ST(i). 3 reads both, writes ST(i) and then pops. 4 uses i = 1 regardless of `op_idx_i`, writes ST(1) and then pops. Codes 5 to 7 behave as code 0. A written register is tagged valid.
- R5: After an accepted popping operation, `busy_o` is high for exactly one cycle. In that cycle the register at ST(0) is tagged empty and the top pointer then increments by 1, so the result written to ST(i) is found at the new ST(i-1).
- R6: An operation whose ST(0) is empty, or whose ST(i) is empty in a form that reads ST(i), sets `underflow_o` = 1 and `c1_o` = 0 from the next cycle, whatever `round_up_i` is. Form 0 never checks ST(i).
- R7: An accepted operation without underflow sets `underflow_o` = 0 and `c1_o` = `round_up_i` from the next cycle.
- R8: On underflow, no register contents or tags change, the pointer does not move and no pop is started (`busy_o` stays 0).
- R9: An operation presented while `busy_o` is high is ignored: it writes nothing and does not change the status outputs.
- R10: `underflow_o` and `c1_o` hold their values across cycles that accept no operation, including pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push a value onto the stack |
| push_data_i | input | DATA_W | Value to push |
| op_valid_i | input | 1 | Operation issued this cycle |
| op_form_i | input | 3 | Operation form code (see R4) |
| op_idx_i | input | PTR_W | Stack-relative index i |
| wb_data_i | input | DATA_W | Result to write back |
| round_up_i | input | 1 | Result was rounded up |
| st0_data_o | output | DATA_W | Contents of ST(0) |
| sti_data_o | output | DATA_W | Contents of ST(i) |
| top_o | output | PTR_W | Top-of-stack pointer |
| tag_empty_o | output | 2**PTR_W | Per-physical-register empty tag |
| busy_o | output | 1 | Pop cycle in progress |
| underflow_o | output | 1 | Last operation hit an empty register |
| c1_o | output | 1 | C1 condition bit of the last operation |

## Verification
The hardest case to reach is an operation that arrives in the single `S_POP` cycle. The bench issues a form-3 operation and, at the next falling edge while `busy_o` is high, drives a second operation and a push carrying a marker value. It then checks that only the pop took effect and the status did not change. Pointer wrap-around needs the stack filled with all eight pushes and then drained with popping operations across index 7 to 0. An underflow on a completely empty stack is forced after a mid-run reset.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [2:0] {
        FORM_MEM      = 3'd0,
        FORM_REG_ST0  = 3'd1,
        FORM_REG_STI  = 3'd2,
        FORM_STI_POP  = 3'd3,
        FORM_IMPLICIT = 3'd4
    } form_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_POP  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fpstk_map.sv
module fpstk_map #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] top_i,
    input  logic [PTR_W-1:0] idx_i,
    output logic [PTR_W-1:0] ph_st0_o,
    output logic [PTR_W-1:0] ph_sti_o,
    output logic [PTR_W-1:0] ph_push_o
);

    // Pointer arithmetic wraps naturally at PTR_W bits.
    assign ph_st0_o  = top_i;
    assign ph_sti_o  = top_i + idx_i;
    assign ph_push_o = top_i - PTR_W'(1);

endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
    parameter int DATA_W = 80,
    parameter int PTR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [PTR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      clr_en_i,
    input  logic [PTR_W-1:0]          clr_addr_i,
    input  logic [PTR_W-1:0]          rd_a_addr_i,
    input  logic [PTR_W-1:0]          rd_b_addr_i,
    output logic [DATA_W-1:0]         rd_a_data_o,
    output logic [DATA_W-1:0]         rd_b_data_o,
    output logic [(1<<PTR_W)-1:0]     empty_o
);

    localparam int NREG = 1 << PTR_W;

    logic [DATA_W-1:0] data_q  [NREG];
    logic              empty_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g]  <= '0;
                empty_q[g] <= 1'b1;
            end else if (wr_en_i && (wr_addr_i == SLOT)) begin
                data_q[g]  <= wr_data_i;
                empty_q[g] <= 1'b0;
            end else if (clr_en_i && (clr_addr_i == SLOT)) begin
                empty_q[g] <= 1'b1;
            end
        end

        assign empty_o[g] = empty_q[g];
    end

    assign rd_a_data_o = data_q[rd_a_addr_i];
    assign rd_b_data_o = data_q[rd_b_addr_i];

    // R5: the slot cleared by a pop reads empty on the following cycle
    p_pop_clears_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> empty_o[$past(clr_addr_i)]);

    // R4: a written slot reads valid and holds the written value
    p_write_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (!empty_o[$past(wr_addr_i)] && (data_q[$past(wr_addr_i)] == $past(wr_data_i))));

    // R9: a pop cycle never carries a write
    p_no_write_in_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && clr_en_i));

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 80,
    parameter int PTR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [DATA_W-1:0]         push_data_i,
    input  logic                      op_valid_i,
    input  logic [2:0]                op_form_i,
    input  logic [PTR_W-1:0]          op_idx_i,
    input  logic [DATA_W-1:0]         wb_data_i,
    input  logic                      round_up_i,
    input  logic [(1<<PTR_W)-1:0]     empty_i,
    input  logic [PTR_W-1:0]          ph_st0_i,
    input  logic [PTR_W-1:0]          ph_sti_i,
    input  logic [PTR_W-1:0]          ph_push_i,
    output logic [PTR_W-1:0]          top_o,
    output logic [PTR_W-1:0]          eff_idx_o,
    output logic                      wr_en_o,
    output logic [PTR_W-1:0]          wr_addr_o,
    output logic [DATA_W-1:0]         wr_data_o,
    output logic                      clr_en_o,
    output logic [PTR_W-1:0]          clr_addr_o,
    output logic                      busy_o,
    output logic                      underflow_o,
    output logic                      c1_o
);

    seq_state_e       state_q, state_d;
    form_e            form;
    logic [PTR_W-1:0] top_q;
    logic             uf_q, c1_q;
    logic             uses_sti, dest_sti, pop_form;
    logic             uf, accept_op, accept_push;

    // Form decode
    always_comb begin
        form      = form_e'(op_form_i);
        uses_sti  = 1'b1;
        dest_sti  = 1'b0;
        pop_form  = 1'b0;
        eff_idx_o = op_idx_i;
        unique case (form)
            FORM_MEM:      uses_sti = 1'b0;
            FORM_REG_ST0:  uses_sti = 1'b1;
            FORM_REG_STI:  dest_sti = 1'b1;
            FORM_STI_POP: begin
                dest_sti = 1'b1;
                pop_form = 1'b1;
            end
            FORM_IMPLICIT: begin
                eff_idx_o = PTR_W'(1);
                dest_sti  = 1'b1;
                pop_form  = 1'b1;
            end
            default:       uses_sti = 1'b0;
        endcase
    end

    assign uf          = empty_i[ph_st0_i] | (uses_sti & empty_i[ph_sti_i]);
    assign accept_op   = (state_q == S_IDLE) & op_valid_i;
    assign accept_push = (state_q == S_IDLE) & ~op_valid_i & push_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        wr_en_o    = 1'b0;
        wr_addr_o  = ph_st0_i;
        wr_data_o  = wb_data_i;
        clr_en_o   = 1'b0;
        clr_addr_o = top_q;
        busy_o     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept_op && !uf) begin
                    wr_en_o   = 1'b1;
                    wr_addr_o = dest_sti ? ph_sti_i : ph_st0_i;
                    if (pop_form) begin
                        state_d = S_POP;
                    end
                end else if (accept_push) begin
                    wr_en_o   = 1'b1;
                    wr_addr_o = ph_push_i;
                    wr_data_o = push_data_i;
                end
            end
            S_POP: begin
                busy_o   = 1'b1;
                clr_en_o = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Pointer and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            uf_q  <= 1'b0;
            c1_q  <= 1'b0;
        end else begin
            if (accept_push) begin
                top_q <= top_q - PTR_W'(1);
            end else if (state_q == S_POP) begin
                top_q <= top_q + PTR_W'(1);
            end
            if (accept_op) begin
                uf_q <= uf;
                c1_q <= ~uf & round_up_i;
            end
        end
    end

    assign top_o       = top_q;
    assign underflow_o = uf_q;
    assign c1_o        = c1_q;

    // R5: a pop cycle advances the pointer by exactly one
    p_pop_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP) |=> (top_q == $past(top_q) + PTR_W'(1)));

    // R5: the pop state lasts a single cycle
    p_pop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP) |=> (state_q == S_IDLE));

    // R2: an accepted push moves the pointer down by one
    p_push_retreat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_push |=> (top_q == $past(top_q) - PTR_W'(1)));

    // R6: underflow forces C1 low
    p_uf_c1_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_op && uf) |=> (underflow_o && !c1_o));

    // R8: underflow starts no pop and leaves the pointer alone
    p_uf_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_op && uf) |=> ((state_q == S_IDLE) && (top_q == $past(top_q))));

    // R10: status holds when no operation is accepted
    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_op |=> ($stable(underflow_o) && $stable(c1_o)));

endmodule

// File: rtl/fpstk_mgr.sv
module fpstk_mgr #(
    parameter int DATA_W = 80,
    parameter int PTR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [DATA_W-1:0]         push_data_i,
    input  logic                      op_valid_i,
    input  logic [2:0]                op_form_i,
    input  logic [PTR_W-1:0]          op_idx_i,
    input  logic [DATA_W-1:0]         wb_data_i,
    input  logic                      round_up_i,
    output logic [DATA_W-1:0]         st0_data_o,
    output logic [DATA_W-1:0]         sti_data_o,
    output logic [PTR_W-1:0]          top_o,
    output logic [(1<<PTR_W)-1:0]     tag_empty_o,
    output logic                      busy_o,
    output logic                      underflow_o,
    output logic                      c1_o
);

    logic [PTR_W-1:0]  top, eff_idx, ph_st0, ph_sti, ph_push;
    logic              wr_en, clr_en;
    logic [PTR_W-1:0]  wr_addr, clr_addr;
    logic [DATA_W-1:0] wr_data;

    fpstk_map #(.PTR_W(PTR_W)) u_map (
        .top_i     (top),
        .idx_i     (eff_idx),
        .ph_st0_o  (ph_st0),
        .ph_sti_o  (ph_sti),
        .ph_push_o (ph_push)
    );

    fpstk_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .clr_en_i    (clr_en),
        .clr_addr_i  (clr_addr),
        .rd_a_addr_i (ph_st0),
        .rd_b_addr_i (ph_sti),
        .rd_a_data_o (st0_data_o),
        .rd_b_data_o (sti_data_o),
        .empty_o     (tag_empty_o)
    );

    fpstk_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .op_valid_i  (op_valid_i),
        .op_form_i   (op_form_i),
        .op_idx_i    (op_idx_i),
        .wb_data_i   (wb_data_i),
        .round_up_i  (round_up_i),
        .empty_i     (tag_empty_o),
        .ph_st0_i    (ph_st0),
        .ph_sti_i    (ph_sti),
        .ph_push_i   (ph_push),
        .top_o       (top),
        .eff_idx_o   (eff_idx),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .clr_en_o    (clr_en),
        .clr_addr_o  (clr_addr),
        .busy_o      (busy_o),
        .underflow_o (underflow_o),
        .c1_o        (c1_o)
    );

    assign top_o = top;

    // R9: a busy cycle is always followed by an idle one
    p_busy_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

endmodule

// File: tb/tb_fpstk_mgr.sv
`timescale 1ns/1ps
module tb_fpstk_mgr;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [DW-1:0] push_data_i = '0;
    logic          op_valid_i = 1'b0;
    logic [2:0]    op_form_i = 3'd0;
    logic [2:0]    op_idx_i = 3'd0;
    logic [DW-1:0] wb_data_i = '0;
    logic          round_up_i = 1'b0;
    logic [DW-1:0] st0_data_o, sti_data_o;
    logic [2:0]    top_o;
    logic [7:0]    tag_empty_o;
    logic          busy_o, underflow_o, c1_o;

    fpstk_mgr #(.DATA_W(DW), .PTR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .op_valid_i(op_valid_i), .op_form_i(op_form_i), .op_idx_i(op_idx_i),
        .wb_data_i(wb_data_i), .round_up_i(round_up_i),
        .st0_data_o(st0_data_o), .sti_data_o(sti_data_o), .top_o(top_o),
        .tag_empty_o(tag_empty_o), .busy_o(busy_o),
        .underflow_o(underflow_o), .c1_o(c1_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model built from the requirements
    logic [DW-1:0] m_data [8];
    bit            m_empty [8];
    int            m_top;
    bit            m_uf, m_c1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_data[k]  = '0;
            m_empty[k] = 1'b1;
        end
        m_top = 0;
        m_uf  = 1'b0;
        m_c1  = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_state(string req);
        logic [7:0] exp_tags;
        @(negedge clk);
        for (int k = 0; k < 8; k++) exp_tags[k] = m_empty[k];
        chk(req, "top", 32'(top_o), 32'(m_top));
        chk(req, "tags", 32'(tag_empty_o), 32'(exp_tags));
        chk(req, "busy", 32'(busy_o), 32'd0);
        chk(req, "underflow", 32'(underflow_o), 32'(m_uf));
        chk(req, "c1", 32'(c1_o), 32'(m_c1));
        chk(req, "st0", 32'(st0_data_o), 32'(m_data[m_top]));
        op_form_i = 3'd0;
        for (int k = 0; k < 8; k++) begin
            op_idx_i = 3'(k);
            #0.5;
            chk(req, $sformatf("st%0d", k), 32'(sti_data_o), 32'(m_data[(m_top + k) % 8]));
        end
        op_idx_i = 3'd0;
    endtask

    task automatic do_push(logic [DW-1:0] v);
        @(negedge clk);
        push_i = 1'b1;
        push_data_i = v;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        m_top = (m_top + 7) % 8;
        m_data[m_top]  = v;
        m_empty[m_top] = 1'b0;
    endtask

    task automatic model_op(int form, int idx, logic [DW-1:0] wb, bit ru, output bit pop);
        int eidx, p0, pi, dst;
        bit uf, rd_i;
        eidx = (form == 4) ? 1 : idx;
        rd_i = (form >= 1 && form <= 4);
        p0 = m_top;
        pi = (m_top + eidx) % 8;
        uf = m_empty[p0] | (rd_i & m_empty[pi]);
        pop = 1'b0;
        if (uf) begin
            m_uf = 1'b1;
            m_c1 = 1'b0;
        end else begin
            dst = (form >= 2 && form <= 4) ? pi : p0;
            m_data[dst]  = wb;
            m_empty[dst] = 1'b0;
            m_uf = 1'b0;
            m_c1 = ru;
            pop = (form == 3 || form == 4);
        end
    endtask

    task automatic do_op(string req, int form, int idx, logic [DW-1:0] wb, bit ru);
        bit pop;
        @(negedge clk);
        op_valid_i = 1'b1;
        op_form_i  = 3'(form);
        op_idx_i   = 3'(idx);
        wb_data_i  = wb;
        round_up_i = ru;
        model_op(form, idx, wb, ru, pop);
        @(posedge clk);
        @(negedge clk);
        op_valid_i = 1'b0;
        op_form_i  = 3'd0;
        op_idx_i   = 3'd0;
        chk(req, "busy after op", 32'(busy_o), 32'(pop));
        if (pop) begin
            @(posedge clk);
            @(negedge clk);
            m_empty[m_top] = 1'b1;
            m_top = (m_top + 1) % 8;
        end
    endtask

    // Scenarios
    task automatic t_reset();
        check_state("R1");
    endtask

    task automatic t_push_map();
        do_push(16'h1111);
        do_push(16'h2222);
        do_push(16'h3333);
        check_state("R2 R3");
    endtask

    task automatic t_forms();
        do_op("R4 R7", 0, 0, 16'hA000, 1'b1);
        check_state("R4 R7");
        do_op("R4", 1, 2, 16'hA001, 1'b0);
        check_state("R4 R7");
        do_op("R4", 2, 1, 16'hA002, 1'b1);
        check_state("R4");
    endtask

    task automatic t_pop_forms();
        logic [DW-1:0] expect_v;
        do_push(16'h4444);
        do_op("R5", 3, 2, 16'hB003, 1'b0);
        check_state("R5");
        expect_v = 16'hB003;
        op_idx_i = 3'd1;
        #0.5;
        chk("R5", "result at new st1", 32'(sti_data_o), 32'(expect_v));
        op_idx_i = 3'd0;
        do_op("R4 R5", 4, 6, 16'hB004, 1'b1);
        check_state("R4 R5");
        chk("R5", "implicit result at st0", 32'(st0_data_o), 32'h0000B004);
    endtask

    task automatic t_underflow();
        do_op("R6 R8", 1, 5, 16'hDEAD, 1'b1);
        check_state("R6 R8");
        do_op("R7", 0, 5, 16'hC000, 1'b1);
        check_state("R6 R7");
    endtask

    task automatic t_push_blocked();
        @(negedge clk);
        push_i = 1'b1;
        push_data_i = 16'hEEEE;
        @(negedge clk);
        push_i = 1'b0;
        // the accepted push above; now push together with an op
        m_top = (m_top + 7) % 8;
        m_data[m_top]  = 16'hEEEE;
        m_empty[m_top] = 1'b0;
        @(negedge clk);
        push_i = 1'b1;
        push_data_i = 16'h5A5A;
        op_valid_i = 1'b1;
        op_form_i  = 3'd0;
        wb_data_i  = 16'hC100;
        round_up_i = 1'b0;
        m_data[m_top] = 16'hC100;
        m_uf = 1'b0;
        m_c1 = 1'b0;
        @(negedge clk);
        push_i = 1'b0;
        op_valid_i = 1'b0;
        check_state("R2");
    endtask

    task automatic t_busy_ignored();
        bit uf_before, c1_before;
        do_op("R5", 0, 0, 16'hC200, 1'b1);
        uf_before = m_uf;
        c1_before = m_c1;
        @(negedge clk);
        op_valid_i = 1'b1;
        op_form_i  = 3'd3;
        op_idx_i   = 3'd1;
        wb_data_i  = 16'hC201;
        round_up_i = 1'b0;
        m_data[(m_top + 1) % 8] = 16'hC201;
        m_uf = 1'b0;
        m_c1 = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "busy", 32'(busy_o), 32'd1);
        op_form_i  = 3'd1;
        op_idx_i   = 3'd0;
        wb_data_i  = 16'hBAD0;
        round_up_i = 1'b1;
        push_i     = 1'b1;
        push_data_i = 16'hBAD1;
        @(posedge clk);
        @(negedge clk);
        op_valid_i = 1'b0;
        push_i = 1'b0;
        m_empty[m_top] = 1'b1;
        m_top = (m_top + 1) % 8;
        chk("R9", "status unchanged uf", 32'(underflow_o), 32'(m_uf));
        chk("R9", "status unchanged c1", 32'(c1_o), 32'(m_c1));
        check_state("R9 R2");
        if (uf_before) chk("R9", "prior uf", 32'(uf_before), 32'd0);
        chk("R7", "prior c1", 32'(c1_before), 32'd1);
    endtask

    task automatic t_wrap();
        apply_reset();
        do_op("R6 R8", 1, 0, 16'h0BAD, 1'b1);
        check_state("R6 R8");
        for (int k = 0; k < 8; k++) do_push(16'h7000 + 16'(k));
        check_state("R2 R3 R10");
        for (int k = 0; k < 7; k++) do_op("R5", 4, 0, 16'h8000 + 16'(k), k[0]);
        check_state("R3 R5");
        do_op("R6", 4, 0, 16'h9999, 1'b1);
        check_state("R6 R8");
        do_push(16'h6000);
        check_state("R10");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_map();
        t_forms();
        t_pop_forms();
        t_underflow();
        t_push_blocked();
        t_busy_ignored();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule